// File: doc/BRIEF.md
# Slot-Scan Sample Sequencer with Result Queue

This block sits between a register bus and a bank of twelve 20-bit channel sample inputs coming from an analog front end. Software programs up to eight slots, each with an enable bit and a channel number, then writes a key byte to a trigger register. The block then walks the slots in ascending order, one slot per clock cycle. For every enabled slot it copies the selected channel's current sample into a 16-entry result queue, and it tags each entry with the slot number.

Software empties the queue through one of two readout words. The first is a peek word that is popped by writing to it. The second pops when it is read, but only while a control bit allows it. A sticky overflow flag records results dropped because the queue was full. The control and slot registers lock while the module enable bit is set, except for a write that turns the module off. Turning the module off also empties the queue. A twelve-source interrupt block with enable, status, set and clear registers drives a single level interrupt. Hardware sets source 0 for every result the scan produces.

Register word map (byte addresses, bus address is 8 bits): control 0x00, trigger 0x04, slot s at 0x10+4*s, peek/write-pop 0x30, read-pop 0x34, interrupt enable 0x40, status 0x44, clear 0x48, set 0x4C. All other addresses read as zero.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every register reads zero, the queue is empty and irq_o is low.
- R2: A write to the trigger register (0x04) whose bits 7:0 equal 0x37 starts a scan, whatever the other bits hold and whether or not the module is enabled. Any other low byte does nothing. A key write that arrives while a scan is running is ignored.
- R3: A scan that is started by the write at clock edge T examines slot k at edge T+1+k, for k from 0 to 7. If that slot is enabled (slot bit 0), the entry {channel sample of the selected channel at that edge, slot number k} is appended to the queue at that edge. Disabled slots take their cycle but append nothing.
- R4: A slot register (0x10+4*s) holds the enable bit in bit 0 and the channel number in bits 11:8. Reads return only those bits. A write with a channel number of 12 or more keeps the previous channel number but still updates the enable bit.
- R5: While control bit 0 (enable) is 1, writes to the control and slot registers are discarded. The one exception is a control write with bit 0 equal to 0, which is applied in full.
- R6: A control write that takes enable from 1 to 0 empties the queue and clears the overflow flag in the same edge.
- R7: Both readout words use this layout: bits 19:0 sample, bits 27:20 queue count, bits 30:28 slot, bit 31 zero. Sample and slot read as zero when the queue is empty.
- R8: Any write to the peek word (0x30) removes the head entry if one exists. Reading the peek word never removes an entry.
- R9: While control bit 12 is 1, reading the read-pop word (0x34) removes the head entry if one exists. While bit 12 is 0, that word's sample and slot fields read as zero and a read removes nothing. The count field is always valid.
- R10: The queue holds 16 entries. An append to a full queue with no removal in the same edge is dropped and sets the sticky overflow flag at control bit 16. An append and a removal in the same edge leave the count unchanged.
- R11: Status bit 0 is set at every edge where the scan produces a result, including dropped ones. Writing 1s to the set register (0x4C) sets status bits, and writing 1s to the clear register (0x48) clears them. When a bit is set and cleared in the same edge, the set wins.
- R12: irq_o is high exactly when some status bit and its matching enable bit (0x40) are both 1. It follows the registers with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (triggers read-pop) |
| reg_addr_i | input | 8 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from address and state |
| chan_data_i | input | 240 | Twelve 20-bit channel samples, channel c at bits 20c+19:20c |
| irq_o | output | 1 | Level interrupt |

## Verification
Register writes take effect at the edge where the strobe is sampled. Read data and irq_o are combinational, so they show the new state half a cycle later. The first scan result appears one edge after the key write, and slot k lands k edges after that. A read-pop or write-pop takes effect at the edge that ends the strobe cycle. The bench drives every stimulus on the falling edge and samples five nanoseconds after it. A behavioural model updates on the rising edge from the same inputs and is compared with the read data and irq_o every cycle. Directed checks read the queue count once per cycle during a scan, which confirms the slot-per-edge timing and the edge at which each same-cycle pop and append is counted.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int SAMPLE_W = 20;
  localparam int NUM_CH   = 12;
  localparam int NUM_SLOT = 8;
  localparam int CH_SEL_W = 4;
  localparam int SLOT_W   = $clog2(NUM_SLOT);
  localparam int NUM_IRQ  = 12;
  localparam int IRQ_CONV = 0;
  localparam logic [7:0] TRIG_KEY = 8'h37;

  // word indices (byte address >> 2)
  localparam int W_CTRL  = 0;
  localparam int W_TRIG  = 1;
  localparam int W_SLOT0 = 4;
  localparam int W_PEEK  = 12;
  localparam int W_RPOP  = 13;
  localparam int W_IEN   = 16;
  localparam int W_IST   = 17;
  localparam int W_ICLR  = 18;
  localparam int W_ISET  = 19;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_RPOP = 12;
  localparam int CTRL_OVF  = 16;

  typedef struct packed {
    logic [SLOT_W-1:0]   slot;
    logic [SAMPLE_W-1:0] data;
  } entry_t;
endpackage

// File: rtl/adc_seq_fifo.sv
module adc_seq_fifo #(
  parameter int DW    = 23,
  parameter int DEPTH = 16,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          drop_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic full, do_push, do_pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (count_o == '0);
  assign full    = (count_o == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign do_push = push_i && (!full || do_pop) && !flush_i;
  assign drop_o  = push_i && full && !do_pop && !flush_i;
  assign rdata_o = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end
endmodule

// File: rtl/adc_seq_scanner.sv
module adc_seq_scanner #(
  parameter int NS = 8,
  parameter int NC = 12,
  parameter int SW = 20,
  parameter int CW = 4,
  localparam int LW = (NS > 1) ? $clog2(NS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NS-1:0]         slot_en_i,
  input  logic [NS-1:0][CW-1:0] slot_ch_i,
  input  logic [NC-1:0][SW-1:0] chan_i,
  output logic                  push_o,
  output logic [SW-1:0]         push_data_o,
  output logic [LW-1:0]         push_slot_o,
  output logic                  busy_o
);
  logic [LW-1:0] idx_q;
  logic [CW-1:0] sel;
  logic          cur_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_q  <= '0;
    end else if (busy_o) begin
      if (idx_q == LW'(NS - 1)) begin
        busy_o <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end else if (start_i) begin
      busy_o <= 1'b1;
      idx_q  <= '0;
    end
  end

  always_comb begin
    sel    = '0;
    cur_en = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (idx_q == LW'(s)) begin
        sel    = slot_ch_i[s];
        cur_en = slot_en_i[s];
      end
    end
  end

  always_comb begin
    push_data_o = '0;
    for (int c = 0; c < NC; c++) begin
      if (32'(sel) == c) push_data_o = chan_i[c];
    end
  end

  assign push_o      = busy_o && cur_en;
  assign push_slot_o = idx_q;
endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
  parameter int N = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic [N-1:0] en_wdata_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] enable_o,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_o <= '0;
      status_o <= '0;
    end else begin
      if (en_we_i) enable_o <= en_wdata_i;
      status_o <= (status_o & ~clr_i) | set_i;
    end
  end

  assign irq_o = |(status_o & enable_o);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_seq_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int ADDR_W     = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic                       reg_re_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [31:0]                reg_wdata_i,
  output logic [31:0]                reg_rdata_o,
  input  logic [NUM_CH*SAMPLE_W-1:0] chan_data_i,
  output logic                       irq_o
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int ENT_W = SLOT_W + SAMPLE_W;

  logic [31:0] word_idx;
  assign word_idx = 32'(reg_addr_i[ADDR_W-1:2]);

  logic is_ctrl, is_trig, is_peek, is_rpop, is_ien, is_iclr, is_iset;
  assign is_ctrl = (word_idx == W_CTRL);
  assign is_trig = (word_idx == W_TRIG);
  assign is_peek = (word_idx == W_PEEK);
  assign is_rpop = (word_idx == W_RPOP);
  assign is_ien  = (word_idx == W_IEN);
  assign is_iclr = (word_idx == W_ICLR);
  assign is_iset = (word_idx == W_ISET);

  logic en_q, rpop_q, ovf_q;
  logic [NUM_SLOT-1:0]               slot_en_q;
  logic [NUM_SLOT-1:0][CH_SEL_W-1:0] slot_ch_q;
  logic [NUM_CH-1:0][SAMPLE_W-1:0]   chan;

  assign chan = chan_data_i;

  // config lock: only a disabling control write passes while enabled
  logic cfg_ok, flush;
  assign cfg_ok = !en_q || (is_ctrl && !reg_wdata_i[CTRL_EN]);
  assign flush  = reg_we_i && is_ctrl && en_q && !reg_wdata_i[CTRL_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      rpop_q <= 1'b0;
    end else if (reg_we_i && is_ctrl && cfg_ok) begin
      en_q   <= reg_wdata_i[CTRL_EN];
      rpop_q <= reg_wdata_i[CTRL_RPOP];
    end
  end

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
    logic slot_we;
    assign slot_we = reg_we_i && cfg_ok && (word_idx == W_SLOT0 + s);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_en_q[s] <= 1'b0;
        slot_ch_q[s] <= '0;
      end else if (slot_we) begin
        slot_en_q[s] <= reg_wdata_i[0];
        if (32'(reg_wdata_i[8 +: CH_SEL_W]) < NUM_CH) slot_ch_q[s] <= reg_wdata_i[8 +: CH_SEL_W];
      end
    end
  end

  // scan engine
  logic                scan_push, scan_busy, scan_start;
  logic [SAMPLE_W-1:0] scan_data;
  logic [SLOT_W-1:0]   scan_slot;

  assign scan_start = reg_we_i && is_trig && (reg_wdata_i[7:0] == TRIG_KEY) && !scan_busy;

  adc_seq_scanner #(
    .NS(NUM_SLOT), .NC(NUM_CH), .SW(SAMPLE_W), .CW(CH_SEL_W)
  ) i_scanner (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (scan_start),
    .slot_en_i   (slot_en_q),
    .slot_ch_i   (slot_ch_q),
    .chan_i      (chan),
    .push_o      (scan_push),
    .push_data_o (scan_data),
    .push_slot_o (scan_slot),
    .busy_o      (scan_busy)
  );

  // result queue
  entry_t           push_ent, head;
  logic [ENT_W-1:0] head_raw;
  logic [CNT_W-1:0] fifo_count;
  logic             fifo_empty, fifo_drop, fifo_pop;

  assign push_ent.slot = scan_slot;
  assign push_ent.data = scan_data;
  assign head          = entry_t'(head_raw);
  assign fifo_pop      = (reg_we_i && is_peek) || (reg_re_i && is_rpop && rpop_q);

  adc_seq_fifo #(
    .DW(ENT_W), .DEPTH(FIFO_DEPTH)
  ) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (scan_push),
    .pop_i   (fifo_pop),
    .wdata_i (push_ent),
    .rdata_o (head_raw),
    .count_o (fifo_count),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (flush)     ovf_q <= 1'b0;
    else if (fifo_drop) ovf_q <= 1'b1;
  end

  // interrupts
  logic [NUM_IRQ-1:0] irq_set, irq_clr, irq_en, irq_st;

  always_comb begin
    irq_set = (reg_we_i && is_iset) ? reg_wdata_i[NUM_IRQ-1:0] : '0;
    irq_set[IRQ_CONV] = irq_set[IRQ_CONV] | scan_push;
  end
  assign irq_clr = (reg_we_i && is_iclr) ? reg_wdata_i[NUM_IRQ-1:0] : '0;

  adc_seq_irq #(.N(NUM_IRQ)) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_we_i    (reg_we_i && is_ien),
    .en_wdata_i (reg_wdata_i[NUM_IRQ-1:0]),
    .set_i      (irq_set),
    .clr_i      (irq_clr),
    .enable_o   (irq_en),
    .status_o   (irq_st),
    .irq_o      (irq_o)
  );

  // read mux
  logic [SAMPLE_W-1:0] head_data;
  logic [SLOT_W-1:0]   head_slot;
  logic [7:0]          cnt8;
  logic                rp_vis;

  assign head_data = fifo_empty ? '0 : head.data;
  assign head_slot = fifo_empty ? '0 : head.slot;
  assign cnt8      = 8'(fifo_count);
  assign rp_vis    = rpop_q;

  always_comb begin
    reg_rdata_o = '0;
    if (is_ctrl) begin
      reg_rdata_o[CTRL_EN]   = en_q;
      reg_rdata_o[CTRL_RPOP] = rpop_q;
      reg_rdata_o[CTRL_OVF]  = ovf_q;
    end else if (is_peek) begin
      reg_rdata_o = {1'b0, head_slot, cnt8, head_data};
    end else if (is_rpop) begin
      reg_rdata_o = {1'b0, rp_vis ? head_slot : '0, cnt8, rp_vis ? head_data : '0};
    end else if (is_ien) begin
      reg_rdata_o[NUM_IRQ-1:0] = irq_en;
    end else if (word_idx == W_IST) begin
      reg_rdata_o[NUM_IRQ-1:0] = irq_st;
    end else begin
      for (int s = 0; s < NUM_SLOT; s++) begin
        if (word_idx == W_SLOT0 + s) begin
          reg_rdata_o[0]               = slot_en_q[s];
          reg_rdata_o[8 +: CH_SEL_W]   = slot_ch_q[s];
        end
      end
    end
  end
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker
  import adc_seq_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                               clk_i,
  input logic                               rst_ni,
  input logic                               we_i,
  input logic [ADDR_W-1:0]                  addr_i,
  input logic [31:0]                        wdata_i,
  input logic [CNT_W-1:0]                   count_i,
  input logic                               busy_i,
  input logic                               push_i,
  input logic                               en_i,
  input logic [NUM_SLOT-1:0][CH_SEL_W-1:0]  slot_ch_i,
  input logic [NUM_IRQ-1:0]                 status_i
);
  logic [31:0] w;
  assign w = 32'(addr_i[ADDR_W-1:2]);

  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(count_i) <= DEPTH);

  assert_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_i) |-> count_i == '0);

  assert_start_key_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(we_i && w == W_TRIG && wdata_i[7:0] == TRIG_KEY));

  assert_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && we_i && w >= W_SLOT0 && w < W_SLOT0 + NUM_SLOT) |=> $stable(slot_ch_i));

  assert_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w == W_PEEK && count_i != '0 && !push_i) |=> count_i == $past(count_i) - 1'b1);

  assert_clr_all_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && w == W_ICLR && wdata_i[NUM_IRQ-1:0] == '1 && !push_i) |=> status_i == '0);

  for (genvar s = 0; s < NUM_SLOT; s++) begin : g_ch
    assert_chsel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      32'(slot_ch_i[s]) < NUM_CH);
  end
endmodule

bind adc_scan_seq adc_seq_checker #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (reg_we_i),
  .addr_i    (reg_addr_i),
  .wdata_i   (reg_wdata_i),
  .count_i   (fifo_count),
  .busy_i    (scan_busy),
  .push_i    (scan_push),
  .en_i      (en_q),
  .slot_ch_i (slot_ch_q),
  .status_i  (irq_st)
);

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  import adc_seq_pkg::*;
  localparam int DEPTH = 16;
  localparam logic [7:0] A_CTRL = 8'h00, A_TRIG = 8'h04, A_PEEK = 8'h30, A_RPOP = 8'h34,
                         A_IEN = 8'h40, A_IST = 8'h44, A_ICLR = 8'h48, A_ISET = 8'h4C;

  logic clk = 0, rst_ni = 0, we = 0, re = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic        irq;
  logic [SAMPLE_W-1:0] chan [NUM_CH];
  logic [NUM_CH*SAMPLE_W-1:0] chan_flat;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always_comb for (int c = 0; c < NUM_CH; c++) chan_flat[c*SAMPLE_W +: SAMPLE_W] = chan[c];

  always #10 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .chan_data_i(chan_flat), .irq_o(irq)
  );

  // ---------------- behavioural model ----------------
  bit m_en, m_rpop, m_ovf, m_busy;
  bit m_sen [NUM_SLOT];
  int m_sch [NUM_SLOT];
  bit [11:0] m_ie, m_st;
  int m_idx;
  bit [22:0] q [$];

  always @(posedge clk or negedge rst_ni) begin
    int w, sz;
    bit ok, flush, pop, push;
    bit [11:0] setv, clrv;
    bit [22:0] pe;
    if (!rst_ni) begin
      m_en = 0; m_rpop = 0; m_ovf = 0; m_busy = 0; m_idx = 0; m_ie = 0; m_st = 0;
      for (int s = 0; s < NUM_SLOT; s++) begin m_sen[s] = 0; m_sch[s] = 0; end
      q.delete();
    end else begin
      w  = int'(addr) / 4;
      sz = q.size();
      ok = !m_en || (w == 0 && !wdata[0]);
      flush = we && w == 0 && m_en && !wdata[0];
      pop  = sz > 0 && ((we && w == 12) || (re && w == 13 && m_rpop));
      push = m_busy && m_sen[m_idx];
      pe   = {3'(m_idx), chan[m_sch[m_idx]]};
      if (flush) begin
        q.delete(); m_ovf = 0;
      end else begin
        if (pop) void'(q.pop_front());
        if (push) begin
          if (sz < DEPTH || pop) q.push_back(pe);
          else m_ovf = 1;
        end
      end
      setv = (we && w == 19) ? wdata[11:0] : 12'h0;
      if (push) setv[0] = 1;
      clrv = (we && w == 18) ? wdata[11:0] : 12'h0;
      m_st = (m_st & ~clrv) | setv;
      if (we && w == 16) m_ie = wdata[11:0];
      if (m_busy) begin
        if (m_idx == NUM_SLOT - 1) begin m_busy = 0; m_idx = 0; end
        else m_idx++;
      end else if (we && w == 1 && wdata[7:0] == 8'h37) begin
        m_busy = 1; m_idx = 0;
      end
      if (we && ok && w == 0) begin m_en = wdata[0]; m_rpop = wdata[12]; end
      if (we && ok && w >= 4 && w < 4 + NUM_SLOT) begin
        m_sen[w-4] = wdata[0];
        if (wdata[11:8] < NUM_CH) m_sch[w-4] = int'(wdata[11:8]);
      end
    end
  end

  function automatic logic [31:0] fword(bit [2:0] sl, int cnt, bit [19:0] d);
    return {1'b0, sl, 8'(cnt), d};
  endfunction

  function automatic logic [31:0] m_rdata();
    int w;
    logic [31:0] r;
    w = int'(addr) / 4;
    r = 0;
    if (w == 0) r = {15'b0, m_ovf, 3'b0, m_rpop, 11'b0, m_en};
    else if (w >= 4 && w < 4 + NUM_SLOT) r = {20'b0, 4'(m_sch[w-4]), 7'b0, m_sen[w-4]};
    else if (w == 12) r = q.size() ? fword(q[0][22:20], q.size(), q[0][19:0]) : fword(0, 0, 0);
    else if (w == 13) r = (q.size() && m_rpop) ? fword(q[0][22:20], q.size(), q[0][19:0])
                                               : fword(0, q.size(), 0);
    else if (w == 16) r = {20'b0, m_ie};
    else if (w == 17) r = {20'b0, m_st};
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      #5;
      chk("R7 cycle model rdata", rdata, m_rdata());
      chk("R12 cycle model irq", {31'b0, irq}, {31'b0, |(m_st & m_ie)});
    end
  end

  // ---------------- stimulus tasks (called at a falling edge) ----------------
  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(posedge clk); @(negedge clk);
    we = 0; wdata = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; re = 1;
    #5 d = rdata;
    @(posedge clk); @(negedge clk);
    re = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int ch [NUM_SLOT] = '{3, 2, 11, 7, 0, 0, 0, 5};
    bit en [NUM_SLOT] = '{1, 0, 1, 1, 0, 1, 0, 1};
    int exp_cnt, seen;
    for (int c = 0; c < NUM_CH; c++) chan[c] = 20'(32'hA0000 + c * 32'h1111 + 7);
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(8'h10, v);  chk("R1 slot0", v, 0);
    rd(A_PEEK, v); chk("R1 peek", v, 0);
    rd(A_IST, v);  chk("R1 status", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R4 slot config
    wr(8'h10, 32'h301); wr(8'h14, 32'h200); wr(8'h18, 32'hB01);
    wr(8'h1C, 32'hC01);
    rd(8'h1C, v); chk("R4 reject ch12", v, 32'h001);
    wr(8'h1C, 32'hFFFF_F701);
    rd(8'h1C, v); chk("R4 extra bits dropped", v, 32'h701);
    wr(8'h1C, 32'hF00);
    rd(8'h1C, v); chk("R4 reject ch15 keeps ch, enable written", v, 32'h700);
    wr(8'h1C, 32'h701);
    wr(8'h24, 32'h001); wr(8'h2C, 32'h501);

    // R2 wrong keys ignored
    wr(A_TRIG, 32'h36); wr(A_TRIG, 32'h3700);
    idle(10);
    rd(A_PEEK, v); chk("R2 wrong key ignored", v, 0);

    // R3 slot-per-edge timing
    wr(A_TRIG, 32'hAB37);
    exp_cnt = 0;
    for (int k = 0; k <= NUM_SLOT; k++) begin
      rd(A_PEEK, v);
      chk("R3 count per edge", {24'b0, v[27:20]}, 32'(exp_cnt));
      if (k < NUM_SLOT && en[k]) exp_cnt++;
    end
    rd(A_IST, v); chk("R11 push sets status0", v, 1);

    // R7/R8 peek and write-pop
    rd(A_PEEK, v); chk("R7 head slot0", v, fword(0, 5, chan[3]));
    rd(A_PEEK, v); chk("R8 read does not pop", v, fword(0, 5, chan[3]));
    wr(A_PEEK, 32'h0);
    rd(A_PEEK, v); chk("R8 write pops", v, fword(2, 4, chan[11]));
    wr(A_PEEK, 32'hFFFF_FFFF);

    // R9 read-pop gating
    rd(A_RPOP, v); chk("R9 gated reads zero", v, fword(0, 3, 0));
    rd(A_RPOP, v); chk("R9 gated no pop", v, fword(0, 3, 0));
    wr(A_CTRL, 32'h1000);
    rd(A_RPOP, v); chk("R9 read-pop head slot3", v, fword(3, 3, chan[7]));
    rd(A_RPOP, v); chk("R9 read-pop head slot5", v, fword(5, 2, chan[0]));
    rd(A_RPOP, v); chk("R9 read-pop head slot7", v, fword(7, 1, chan[5]));
    rd(A_PEEK, v); chk("R7 empty reads zero", v, 0);

    // R2 retrigger during scan ignored
    wr(A_TRIG, 32'h37); idle(2);
    wr(A_TRIG, 32'h37); idle(10);
    rd(A_PEEK, v); chk("R2 retrigger ignored", {24'b0, v[27:20]}, 5);

    // R11/R12 interrupts
    chk("R12 irq low while disabled", {31'b0, irq}, 0);
    wr(A_IEN, 32'h1); #5 chk("R12 irq high", {31'b0, irq}, 1);
    wr(A_ICLR, 32'h1); #5 chk("R12 irq low after clear", {31'b0, irq}, 0);
    rd(A_IST, v); chk("R11 clear", v, 0);
    wr(A_ISET, 32'h20);
    rd(A_IST, v); chk("R11 set", v, 32'h20);
    chk("R12 masked source", {31'b0, irq}, 0);
    wr(A_IEN, 32'h21); #5 chk("R12 set source enabled", {31'b0, irq}, 1);
    wr(A_ICLR, 32'hFFF);
    rd(A_IST, v); chk("R11 clear all", v, 0);
    wr(A_IEN, 32'h0);

    // R5 lock
    wr(A_CTRL, 32'h1001);
    rd(A_CTRL, v); chk("R5 enable", v, 32'h1001);
    wr(8'h10, 32'h901);
    rd(8'h10, v); chk("R5 slot locked", v, 32'h301);
    wr(A_CTRL, 32'h0001);
    rd(A_CTRL, v); chk("R5 ctrl locked", v, 32'h1001);

    // R10 overflow
    for (int i = 0; i < 3; i++) begin wr(A_TRIG, 32'h37); idle(9); end
    rd(A_PEEK, v); chk("R10 full count", {24'b0, v[27:20]}, 16);
    rd(A_CTRL, v); chk("R10 overflow flag", v, 32'h11001);
    wr(A_TRIG, 32'h37);
    for (int i = 0; i < NUM_SLOT; i++) wr(A_PEEK, 32'h0);
    seen = 16;
    for (int k = 0; k < NUM_SLOT; k++) if (!en[k]) seen--;
    rd(A_PEEK, v); chk("R10 pop+push same edge", {24'b0, v[27:20]}, 32'(seen));

    // R6 flush
    wr(A_CTRL, 32'h0);
    rd(A_PEEK, v); chk("R6 flush empties", v, 0);
    rd(A_CTRL, v); chk("R6 overflow cleared", v, 0);

    idle(2);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule